// File: doc/BRIEF.md
# Virtual Interrupt List Register Array

This block holds a small set of list slots through which a hypervisor presents virtual interrupts to one guest CPU interface. Each slot carries a two-bit state, a virtual interrupt ID, a flag that ties the slot to a physical interrupt, and the ID of that physical interrupt. The hypervisor fills slots only while it holds the guest interface stalled. Outside a stall, the guest side issues two operations. An acknowledge returns the virtual ID of a pending slot and marks that slot active. A deactivate, which carries a virtual ID, retires the matching active slot.

When the guest retires a slot that is tied to a physical interrupt, the block sends a single-cycle deactivate request with the stored physical ID toward the physical distributor. The physical interrupt is then released at the same moment as the guest's virtual one. A tied slot must never hold pending and active at the same time, so a host write that asks for that combination on a tied slot is refused. A per-slot empty vector lets the hypervisor find slots it can reuse.

Top module: `vlist_regs`

## Requirements
- R1: After reset every slot is Invalid, `empty_o` is all ones, and `ack_vld_o`, `phys_deact_o`, `wr_reject_o` and `deact_err_o` are low.
- R2: Slot state codes are 00 Invalid, 01 Pending, 10 Active and 11 Pending+Active. A host write with `stall_i` high stores state, link flag, virtual ID and physical ID into slot `wr_idx_i` at the next clock edge. Bit i of `empty_o` is high exactly when slot i holds Invalid.
- R3: A host write with `wr_hw_i` high and state 11 leaves the slot unchanged, and `wr_reject_o` pulses high for one cycle after the write edge.
- R4: A host write with `stall_i` low has no effect on any slot and raises no reject.
- R5: An acknowledge selects the Pending slot (state 01 only) with the lowest index and moves it to Active. In the next cycle `ack_vld_o` is high and `ack_id_o` holds that slot's virtual ID.
- R6: An acknowledge with no Pending slot changes nothing, and in the next cycle it returns `ack_id_o` as all ones with `ack_vld_o` high.
- R7: A deactivate selects the lowest-index slot that is Active or Pending+Active and whose virtual ID equals `deact_id_i`. Active becomes Invalid, and Pending+Active becomes Pending.
- R8: When the deactivated slot has its link flag set, `phys_deact_o` is high for the single cycle after the edge, with `phys_pid_o` holding the slot's physical ID. An unlinked slot produces no request.
- R9: A deactivate that matches no slot changes no slot and raises no physical request. It sets `deact_err_o`, which stays high until reset.
- R10: While `stall_i` is high, acknowledge and deactivate are ignored. No slot changes and neither `ack_vld_o` nor `phys_deact_o` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Holds the guest interface idle and enables host writes |
| wr_en_i | input | 1 | Host write strobe |
| wr_idx_i | input | IW | Slot index for the host write |
| wr_state_i | input | 2 | State code to write |
| wr_hw_i | input | 1 | Link-to-physical flag to write |
| wr_vid_i | input | VID_W | Virtual ID to write |
| wr_pid_i | input | PID_W | Physical ID to write |
| wr_reject_o | output | 1 | One-cycle pulse when a write is refused |
| ack_i | input | 1 | Guest acknowledge strobe |
| ack_vld_o | output | 1 | Acknowledge result valid |
| ack_id_o | output | VID_W | Acknowledged virtual ID, or all ones |
| deact_i | input | 1 | Guest deactivate strobe |
| deact_id_i | input | VID_W | Virtual ID to deactivate |
| phys_deact_o | output | 1 | One-cycle deactivate request to the distributor |
| phys_pid_o | output | PID_W | Physical ID of the request |
| deact_err_o | output | 1 | Sticky flag for unmatched deactivates |
| empty_o | output | NUM_LR | Per-slot Invalid indication |

## Verification
The assertions check on every cycle that no linked slot ever holds Pending+Active, and that an acknowledged slot lands in Active. They also check that a slot with no operation aimed at it keeps its contents, that the error flag never falls, and that a stall suppresses guest results. The bench's scenarios are needed to show the things that depend on choosing among slots. These are lowest-index selection among several pending or matching slots, the returned IDs, the physical ID carried by each request, and the spurious value on an empty acknowledge. A reference model in the bench tracks every slot under mixed random host and guest traffic.

// File: rtl/vlr_pkg.sv
package vlr_pkg;

    localparam int VID_W = 10;
    localparam int PID_W = 10;

    typedef enum logic [1:0] {
        LR_INV  = 2'b00,
        LR_PEND = 2'b01,
        LR_ACT  = 2'b10,
        LR_PACT = 2'b11
    } lr_state_e;

    typedef struct packed {
        lr_state_e          st;
        logic               hw;
        logic [VID_W-1:0]   vid;
        logic [PID_W-1:0]   pid;
    } lr_entry_t;

    function automatic logic is_active(lr_state_e s);
        return (s == LR_ACT) || (s == LR_PACT);
    endfunction

    function automatic logic linked_combo_bad(logic hw, lr_state_e s);
        return hw && (s == LR_PACT);
    endfunction

    function automatic lr_state_e after_deact(lr_state_e s);
        return (s == LR_PACT) ? LR_PEND : LR_INV;
    endfunction

endpackage

// File: rtl/vlr_entry.sv
module vlr_entry
    import vlr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_hit,
    input  lr_entry_t wr_data,
    input  logic      ack_hit,
    input  logic      deact_hit,
    output lr_entry_t cur
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (wr_hit) begin
            cur <= wr_data;
        end else if (ack_hit) begin
            cur.st <= LR_ACT;
        end else if (deact_hit) begin
            cur.st <= after_deact(cur.st);
        end
    end

    AST_HW_NO_PACT: assert property (@(posedge clk) disable iff (rst)
        !(cur.hw && cur.st == LR_PACT)); // R3

    AST_ACK_ONLY_PENDING: assert property (@(posedge clk) disable iff (rst)
        ack_hit |-> cur.st == LR_PEND); // R5

    AST_ACK_GOES_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        ack_hit |=> cur.st == LR_ACT); // R5

    AST_DEACT_ON_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        deact_hit |-> is_active(cur.st)); // R7

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !(wr_hit || ack_hit || deact_hit) |=> $stable(cur)); // R4

endmodule

// File: rtl/vlr_pick.sv
module vlr_pick #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  grant
);

    always_comb begin
        any   = 1'b0;
        idx   = '0;
        grant = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any   = 1'b1;
                idx   = IW'(i);
                grant = N'(1) << i;
            end
        end
    end

    always_comb begin
        AST_GRANT_IN_REQ: assert ((grant & ~req) == '0); // R5
    end

endmodule

// File: rtl/vlist_regs.sv
module vlist_regs
    import vlr_pkg::*;
#(
    parameter int NUM_LR = 4,
    localparam int IW = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stall_i,
    input  logic              wr_en_i,
    input  logic [IW-1:0]     wr_idx_i,
    input  logic [1:0]        wr_state_i,
    input  logic              wr_hw_i,
    input  logic [VID_W-1:0]  wr_vid_i,
    input  logic [PID_W-1:0]  wr_pid_i,
    output logic              wr_reject_o,
    input  logic              ack_i,
    output logic              ack_vld_o,
    output logic [VID_W-1:0]  ack_id_o,
    input  logic              deact_i,
    input  logic [VID_W-1:0]  deact_id_i,
    output logic              phys_deact_o,
    output logic [PID_W-1:0]  phys_pid_o,
    output logic              deact_err_o,
    output logic [NUM_LR-1:0] empty_o
);

    lr_entry_t          ent [NUM_LR];
    lr_entry_t          wr_data;
    logic               wr_bad, wr_go, ack_go, dx_go;
    logic [NUM_LR-1:0]  pend_req, act_req, ack_gnt, dx_gnt;
    logic [NUM_LR-1:0]  wr_hit, ack_hit, dx_hit;
    logic               ack_any, dx_any;
    logic [IW-1:0]      ack_idx, dx_idx;

    logic               ack_vld_q, phys_q, rej_q, err_q;
    logic [VID_W-1:0]   ack_id_q;
    logic [PID_W-1:0]   phys_pid_q;

    assign wr_data = '{st: lr_state_e'(wr_state_i), hw: wr_hw_i,
                       vid: wr_vid_i, pid: wr_pid_i};
    assign wr_bad  = linked_combo_bad(wr_hw_i, lr_state_e'(wr_state_i));
    assign wr_go   = stall_i && wr_en_i && !wr_bad;
    assign ack_go  = !stall_i && ack_i;
    assign dx_go   = !stall_i && deact_i;

    for (genvar g = 0; g < NUM_LR; g++) begin : g_slot
        assign pend_req[g] = (ent[g].st == LR_PEND);
        assign act_req[g]  = is_active(ent[g].st) && (ent[g].vid == deact_id_i);
        assign wr_hit[g]   = wr_go && (wr_idx_i == IW'(g));
        assign ack_hit[g]  = ack_go && ack_gnt[g];
        assign dx_hit[g]   = dx_go && dx_gnt[g];
        assign empty_o[g]  = (ent[g].st == LR_INV);

        vlr_entry u_entry (
            .clk       (clk),
            .rst       (rst),
            .wr_hit    (wr_hit[g]),
            .wr_data   (wr_data),
            .ack_hit   (ack_hit[g]),
            .deact_hit (dx_hit[g]),
            .cur       (ent[g])
        );
    end

    vlr_pick #(.N(NUM_LR)) u_ack_pick (
        .req   (pend_req),
        .any   (ack_any),
        .idx   (ack_idx),
        .grant (ack_gnt)
    );

    vlr_pick #(.N(NUM_LR)) u_dx_pick (
        .req   (act_req),
        .any   (dx_any),
        .idx   (dx_idx),
        .grant (dx_gnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_vld_q  <= 1'b0;
            ack_id_q   <= '1;
            phys_q     <= 1'b0;
            phys_pid_q <= '0;
            rej_q      <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            ack_vld_q <= ack_go;
            if (ack_go) begin
                ack_id_q <= ack_any ? ent[ack_idx].vid : '1;
            end
            phys_q <= dx_go && dx_any && ent[dx_idx].hw;
            if (dx_go && dx_any) begin
                phys_pid_q <= ent[dx_idx].pid;
            end
            rej_q <= stall_i && wr_en_i && wr_bad;
            if (dx_go && !dx_any) begin
                err_q <= 1'b1;
            end
        end
    end

    assign ack_vld_o    = ack_vld_q;
    assign ack_id_o     = ack_id_q;
    assign phys_deact_o = phys_q;
    assign phys_pid_o   = phys_pid_q;
    assign wr_reject_o  = rej_q;
    assign deact_err_o  = err_q;

    AST_PHYS_FROM_DEACT: assert property (@(posedge clk) disable iff (rst)
        phys_deact_o |-> $past(dx_go)); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        deact_err_o |=> deact_err_o); // R9

    AST_REJECT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        wr_reject_o |-> $past(stall_i && wr_en_i && wr_hw_i)); // R3

    AST_NO_REJECT_RUNNING: assert property (@(posedge clk) disable iff (rst)
        !stall_i |=> !wr_reject_o); // R4

    AST_STALL_BLOCKS_GUEST: assert property (@(posedge clk) disable iff (rst)
        stall_i |=> !ack_vld_o && !phys_deact_o); // R10

    AST_SPURIOUS_WHEN_NONE: assert property (@(posedge clk) disable iff (rst)
        (ack_go && pend_req == '0) |=> ack_vld_o && ack_id_o == '1); // R6

endmodule

// File: tb/vlist_regs_tb.sv
module vlist_regs_tb;
    import vlr_pkg::*;

    localparam int N  = 4;
    localparam int IW = 2;
    localparam logic [VID_W-1:0] SPUR = '1;

    logic clk = 1'b0;
    logic rst;
    logic stall_i, wr_en_i, wr_hw_i, ack_i, deact_i;
    logic [IW-1:0] wr_idx_i;
    logic [1:0] wr_state_i;
    logic [VID_W-1:0] wr_vid_i, deact_id_i, ack_id_o;
    logic [PID_W-1:0] wr_pid_i, phys_pid_o;
    logic wr_reject_o, ack_vld_o, phys_deact_o, deact_err_o;
    logic [N-1:0] empty_o;

    always #5 clk = ~clk;

    vlist_regs #(.NUM_LR(N)) u_dut (
        .clk(clk), .rst(rst), .stall_i(stall_i), .wr_en_i(wr_en_i),
        .wr_idx_i(wr_idx_i), .wr_state_i(wr_state_i), .wr_hw_i(wr_hw_i),
        .wr_vid_i(wr_vid_i), .wr_pid_i(wr_pid_i), .wr_reject_o(wr_reject_o),
        .ack_i(ack_i), .ack_vld_o(ack_vld_o), .ack_id_o(ack_id_o),
        .deact_i(deact_i), .deact_id_i(deact_id_i), .phys_deact_o(phys_deact_o),
        .phys_pid_o(phys_pid_o), .deact_err_o(deact_err_o), .empty_o(empty_o)
    );

    logic [1:0]       m_st  [N];
    logic             m_hw  [N];
    logic [VID_W-1:0] m_vid [N];
    logic [PID_W-1:0] m_pid [N];
    logic             m_err;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [N-1:0] exp_empty();
        logic [N-1:0] e;
        for (int i = 0; i < N; i++) e[i] = (m_st[i] == 2'b00);
        return e;
    endfunction

    task automatic cycle(string tag, logic s, logic we, logic [IW-1:0] wi,
                         logic [1:0] ws, logic wh, logic [VID_W-1:0] wv,
                         logic [PID_W-1:0] wp, logic a, logic d,
                         logic [VID_W-1:0] di);
        int dm, am;
        logic e_rej, e_av, e_ph;
        logic [VID_W-1:0] e_id;
        logic [PID_W-1:0] e_pid;
        stall_i = s; wr_en_i = we; wr_idx_i = wi; wr_state_i = ws;
        wr_hw_i = wh; wr_vid_i = wv; wr_pid_i = wp;
        ack_i = a; deact_i = d; deact_id_i = di;
        e_rej = 0; e_av = 0; e_ph = 0; e_id = '0; e_pid = '0;
        dm = -1; am = -1;
        if (s) begin
            if (we) begin
                if (wh && ws == 2'b11) e_rej = 1;
                else begin
                    m_st[wi] = ws; m_hw[wi] = wh; m_vid[wi] = wv; m_pid[wi] = wp;
                end
            end
        end else begin
            for (int i = 0; i < N; i++)
                if (d && dm < 0 && m_st[i][1] && m_vid[i] == di) dm = i;
            for (int i = 0; i < N; i++)
                if (a && am < 0 && m_st[i] == 2'b01) am = i;
            if (d) begin
                if (dm >= 0) begin
                    if (m_hw[dm]) begin e_ph = 1; e_pid = m_pid[dm]; end
                    m_st[dm] = (m_st[dm] == 2'b11) ? 2'b01 : 2'b00;
                end else m_err = 1;
            end
            if (a) begin
                e_av = 1;
                e_id = (am >= 0) ? m_vid[am] : SPUR;
                if (am >= 0) m_st[am] = 2'b10;
            end
        end
        @(posedge clk); #1;
        chk({tag, " R3 reject"}, 32'(wr_reject_o), 32'(e_rej));
        chk({tag, " R5 ack_vld"}, 32'(ack_vld_o), 32'(e_av));
        if (e_av) chk({tag, (am >= 0) ? " R5 ack_id" : " R6 spurious"}, 32'(ack_id_o), 32'(e_id));
        chk({tag, " R8 phys"}, 32'(phys_deact_o), 32'(e_ph));
        if (e_ph) chk({tag, " R8 pid"}, 32'(phys_pid_o), 32'(e_pid));
        chk({tag, " R9 err"}, 32'(deact_err_o), 32'(m_err));
        chk({tag, " R2 empty"}, 32'(empty_o), 32'(exp_empty()));
        @(negedge clk);
    endtask

    task automatic host_wr(string tag, logic s, logic [IW-1:0] wi, logic [1:0] ws,
                           logic wh, logic [VID_W-1:0] wv, logic [PID_W-1:0] wp);
        cycle(tag, s, 1'b1, wi, ws, wh, wv, wp, 1'b0, 1'b0, '0);
    endtask

    task automatic guest(string tag, logic s, logic a, logic d, logic [VID_W-1:0] di);
        cycle(tag, s, 1'b0, '0, 2'b00, 1'b0, '0, '0, a, d, di);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1; stall_i = 0; wr_en_i = 0; wr_idx_i = '0; wr_state_i = '0;
        wr_hw_i = 0; wr_vid_i = '0; wr_pid_i = '0; ack_i = 0; deact_i = 0;
        deact_id_i = '0;
        for (int i = 0; i < N; i++) begin
            m_st[i] = 0; m_hw[i] = 0; m_vid[i] = '0; m_pid[i] = '0;
        end
        m_err = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R1 reset state
        chk("R1 empty", 32'(empty_o), 32'hF);
        chk("R1 ack_vld", 32'(ack_vld_o), 0);
        chk("R1 phys", 32'(phys_deact_o), 0);
        chk("R1 reject", 32'(wr_reject_o), 0);
        chk("R1 err", 32'(deact_err_o), 0);

        host_wr("R4 no-stall write", 1'b0, 2'd0, 2'b01, 1'b1, 10'd5, 10'h33);
        host_wr("R2 write", 1'b1, 2'd2, 2'b01, 1'b1, 10'd5, 10'h33);
        host_wr("R2 write", 1'b1, 2'd1, 2'b01, 1'b0, 10'd3, 10'h11);
        host_wr("R3 linked P+A", 1'b1, 2'd0, 2'b11, 1'b1, 10'd8, 10'h22);
        guest("R10 stalled ack", 1'b1, 1'b1, 1'b0, '0);
        guest("R5 ack lowest", 1'b0, 1'b1, 1'b0, '0);
        guest("R5 ack next", 1'b0, 1'b1, 1'b0, '0);
        guest("R6 ack none", 1'b0, 1'b1, 1'b0, '0);
        guest("R10 stalled deact", 1'b1, 1'b0, 1'b1, 10'd5);
        guest("R9 unmatched", 1'b0, 1'b0, 1'b1, 10'd9);
        guest("R8 linked deact", 1'b0, 1'b0, 1'b1, 10'd5);
        guest("R7 plain deact", 1'b0, 1'b0, 1'b1, 10'd3);
        host_wr("R7 setup", 1'b1, 2'd3, 2'b11, 1'b0, 10'd4, 10'h07);
        host_wr("R7 setup", 1'b1, 2'd0, 2'b10, 1'b1, 10'd4, 10'h2A);
        guest("R7 lowest match", 1'b0, 1'b0, 1'b1, 10'd4);
        guest("R7 P+A to pending", 1'b0, 1'b1, 1'b1, 10'd4);
        guest("R5 reack", 1'b0, 1'b1, 1'b0, '0);

        for (int k = 0; k < 3000; k++) begin
            cycle("rand", ($urandom % 3) == 0, ($urandom % 2) == 0,
                  IW'($urandom), 2'($urandom), ($urandom % 2) == 0,
                  VID_W'($urandom % 6), PID_W'($urandom), ($urandom % 2) == 0,
                  ($urandom % 2) == 0, VID_W'($urandom % 7));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule